// File: doc/BRIEF.md
# Bus Target Selection Detector

This block watches the control and data lines of a parallel SCSI-style bus and decides when this device has been chosen as a target. The bus lines arrive as asynchronous levels, true when asserted, and pass through a synchronizer. The device is selected when a selection line goes high, or the busy line is released while selection is held, and the data bus shows a bit for one of the target IDs enabled in `id_enable`. When that happens the block publishes a selection status word. It raises a request to drive busy, records a sticky selected latch, and some time later samples the attention line to tell a legacy host from a current one.

A second path filters bus reset. A rising reset line starts a timer. A one-cycle reset pulse is issued only if the line is still high when the timer runs out, and nothing is issued while the device itself drives the selection line. The surrounding controller asserts `bus_free` to go back to bus-free, which drops the response.

Top module: `bus_select_detect`

## Requirements
- R1: A selection is accepted only when the synchronized selection line is high and the synchronized busy line is low at the evaluation event. Holding both high produces no status.
- R2: The accepted ID is the lowest index i (0..7) for which both `data[i]` and `id_enable[i]` are 1. If no bit matches, the status stays zero. The status word holds `succeeded` in bit 4, `atn` in bit 3 and the ID in bits 2:0. `atn` is 1 when first set.
- R3: Evaluation happens on a rising edge of the synchronized selection line and on a falling edge of the synchronized busy line.
- R4: Evaluation events are ignored while `own_bsy_drive` is 1 or while the block's own busy request is active. An established status is then unchanged by later selections.
- R5: `drive_bsy` rises in the same cycle that the status word shows success.
- R6: ATN_DELAY_NS after the response starts, the attention line is sampled. If it is low, status bit 3 is cleared and `legacy_mode` becomes 1. If it is high, bit 3 stays 1 and `legacy_mode` becomes 0.
- R7: `sel_latched` becomes 1 on an accepted selection and stays 1 after the host releases selection, until bus-free.
- R8: A reset line held for RST_FILTER_NS or longer gives exactly one `bus_reset` pulse of one cycle. A shorter glitch gives none.
- R9: No `bus_reset` pulse is issued for a reset rising edge while `own_sel_drive` is 1.
- R10: `bus_free` clears the status word, `drive_bsy` and `sel_latched` on the next edge, and wins over a selection evaluated in the same cycle.
- R11: Bus inputs pass through a two-stage synchronizer. Status first shows success on the third clock edge after the selection line is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Selection line, high when asserted |
| bus_bsy | input | 1 | Busy line, high when asserted |
| bus_atn | input | 1 | Attention line, high when asserted |
| bus_rst | input | 1 | Bus reset line, high when asserted |
| bus_data | input | 8 | Data bus |
| id_enable | input | 8 | One bit per enabled target ID |
| own_bsy_drive | input | 1 | Device already drives busy |
| own_sel_drive | input | 1 | Device drives the selection line |
| bus_free | input | 1 | Return to bus-free |
| sel_status | output | 5 | {succeeded, atn, id[2:0]} |
| sel_latched | output | 1 | Sticky selected flag |
| drive_bsy | output | 1 | Request to drive busy |
| legacy_mode | output | 1 | Legacy host detected |
| bus_reset | output | 1 | Filtered bus reset pulse |

## Verification
Two functions can act on the same edge. The first pair is a selection evaluation and a bus-free command. The bench raises selection, counts the two synchronizer edges, and puts `bus_free` on exactly the edge where the evaluation would register. It expects the status to stay zero. The second pair is the reset filter and a selection. Both start together, and the bench expects one reset pulse and an intact status word.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

    localparam int ID_COUNT = 8;
    localparam int ID_W     = $clog2(ID_COUNT);

    typedef struct packed {
        logic            won;
        logic            atn;
        logic [ID_W-1:0] id;
    } sel_status_t;

    function automatic logic [ID_W:0] pick_id(input logic [ID_COUNT-1:0] data,
                                              input logic [ID_COUNT-1:0] en);
        logic [ID_W:0] r;
        r = '0;
        for (int i = ID_COUNT - 1; i >= 0; i--) begin
            if (data[i] && en[i]) r = {1'b1, ID_W'(i)};
        end
        return r;
    endfunction

    function automatic int ns_to_cycles(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/bsd_sync.sv
module bsd_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else if (s == 0) chain[s] <= d;
                else chain[s] <= chain[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bsd_rst_filter.sv
module bsd_rst_filter #(
    parameter int HOLD_CYC = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic rst_s,
    input  logic own_sel_drive,
    output logic bus_reset
);
    localparam int CW = $clog2(HOLD_CYC + 1);

    logic          rst_prev;
    logic          busy;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_prev  <= 1'b0;
            busy      <= 1'b0;
            cnt       <= '0;
            bus_reset <= 1'b0;
        end else begin
            rst_prev  <= rst_s;
            bus_reset <= 1'b0;
            if (busy) begin
                if (own_sel_drive) begin
                    busy <= 1'b0;
                end else if (cnt <= CW'(1)) begin
                    busy      <= 1'b0;
                    bus_reset <= rst_s;
                end else begin
                    cnt <= cnt - CW'(1);
                end
            end else if (rst_s && !rst_prev && !own_sel_drive) begin
                busy <= 1'b1;
                cnt  <= CW'(HOLD_CYC);
            end
        end
    end
endmodule

// File: rtl/bsd_atn_probe.sv
module bsd_atn_probe #(
    parameter int DELAY_CYC = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic abort,
    input  logic atn_s,
    output logic done,
    output logic atn_seen
);
    localparam int CW = $clog2(DELAY_CYC + 1);

    logic          busy;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cnt      <= '0;
            done     <= 1'b0;
            atn_seen <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                busy <= 1'b0;
            end else if (start) begin
                busy <= 1'b1;
                cnt  <= CW'(DELAY_CYC);
            end else if (busy) begin
                if (cnt <= CW'(1)) begin
                    busy     <= 1'b0;
                    done     <= 1'b1;
                    atn_seen <= atn_s;
                end else begin
                    cnt <= cnt - CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/bsd_sel_eval.sv
module bsd_sel_eval
    import bsd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sel_s,
    input  logic                bsy_s,
    input  logic [ID_COUNT-1:0] data_s,
    input  logic [ID_COUNT-1:0] id_enable,
    input  logic                own_bsy_drive,
    input  logic                bus_free,
    input  logic                probe_done,
    input  logic                probe_atn,
    output logic                accept,
    output sel_status_t         status,
    output logic                drive_bsy,
    output logic                sel_latched,
    output logic                legacy_mode
);
    logic          sel_prev, bsy_prev;
    logic          sel_rise, bsy_fall, evt;
    logic [ID_W:0] pick;

    assign sel_rise = sel_s && !sel_prev;
    assign bsy_fall = !bsy_s && bsy_prev;
    assign evt      = (sel_rise || bsy_fall) && !(own_bsy_drive || drive_bsy);
    assign pick     = pick_id(data_s, id_enable);
    assign accept   = evt && sel_s && !bsy_s && pick[ID_W] && !bus_free;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_prev    <= 1'b0;
            bsy_prev    <= 1'b0;
            status      <= '0;
            drive_bsy   <= 1'b0;
            sel_latched <= 1'b0;
            legacy_mode <= 1'b0;
        end else begin
            sel_prev <= sel_s;
            bsy_prev <= bsy_s;
            if (bus_free) begin
                status      <= '0;
                drive_bsy   <= 1'b0;
                sel_latched <= 1'b0;
            end else if (accept) begin
                status.won  <= 1'b1;
                status.atn  <= 1'b1;
                status.id   <= pick[ID_W-1:0];
                drive_bsy   <= 1'b1;
                sel_latched <= 1'b1;
            end else if (probe_done) begin
                status.atn  <= probe_atn;
                legacy_mode <= !probe_atn;
            end
        end
    end
endmodule

// File: rtl/bus_select_detect.sv
module bus_select_detect
    import bsd_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 20,
    parameter int RST_FILTER_NS = 500,
    parameter int ATN_DELAY_NS  = 100,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_sel,
    input  logic       bus_bsy,
    input  logic       bus_atn,
    input  logic       bus_rst,
    input  logic [7:0] bus_data,
    input  logic [7:0] id_enable,
    input  logic       own_bsy_drive,
    input  logic       own_sel_drive,
    input  logic       bus_free,
    output logic [4:0] sel_status,
    output logic       sel_latched,
    output logic       drive_bsy,
    output logic       legacy_mode,
    output logic       bus_reset
);
    localparam int RST_CYC = ns_to_cycles(RST_FILTER_NS, CLK_PERIOD_NS);
    localparam int ATN_CYC = ns_to_cycles(ATN_DELAY_NS, CLK_PERIOD_NS);
    localparam int SYNC_W  = ID_COUNT + 4;

    logic [SYNC_W-1:0]   sync_q;
    logic                sel_s, bsy_s, atn_s, rst_s;
    logic [ID_COUNT-1:0] data_s;
    logic                accept, probe_done, probe_atn;
    sel_status_t         status;

    bsd_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({bus_sel, bus_bsy, bus_atn, bus_rst, bus_data}),
        .q   (sync_q)
    );

    assign {sel_s, bsy_s, atn_s, rst_s, data_s} = sync_q;

    bsd_sel_eval u_eval (
        .clk          (clk),
        .rst          (rst),
        .sel_s        (sel_s),
        .bsy_s        (bsy_s),
        .data_s       (data_s),
        .id_enable    (id_enable),
        .own_bsy_drive(own_bsy_drive),
        .bus_free     (bus_free),
        .probe_done   (probe_done),
        .probe_atn    (probe_atn),
        .accept       (accept),
        .status       (status),
        .drive_bsy    (drive_bsy),
        .sel_latched  (sel_latched),
        .legacy_mode  (legacy_mode)
    );

    bsd_atn_probe #(.DELAY_CYC(ATN_CYC)) u_probe (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .abort   (bus_free),
        .atn_s   (atn_s),
        .done    (probe_done),
        .atn_seen(probe_atn)
    );

    bsd_rst_filter #(.HOLD_CYC(RST_CYC)) u_rstf (
        .clk          (clk),
        .rst          (rst),
        .rst_s        (rst_s),
        .own_sel_drive(own_sel_drive),
        .bus_reset    (bus_reset)
    );

    assign sel_status = status;
endmodule

// File: rtl/bsd_checker.sv
module bsd_checker (
    input logic       clk,
    input logic       rst,
    input logic       sel_s,
    input logic       bsy_s,
    input logic       rst_s,
    input logic       bus_free,
    input logic       own_sel_drive,
    input logic [4:0] sel_status,
    input logic       drive_bsy,
    input logic       sel_latched,
    input logic       legacy_mode,
    input logic       bus_reset
);
    assert_sel_window_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_status[4]) |-> ($past(sel_s) && !$past(bsy_s)));

    assert_drive_has_status_R5: assert property (@(posedge clk) disable iff (rst)
        drive_bsy |-> sel_status[4]);

    assert_legacy_clears_atn_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(legacy_mode) |-> !sel_status[3]);

    assert_latch_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (sel_latched && !bus_free) |=> sel_latched);

    assert_reset_needs_line_R8: assert property (@(posedge clk) disable iff (rst)
        bus_reset |-> $past(rst_s));

    assert_reset_single_R8: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> !bus_reset);

    assert_reset_blocked_R9: assert property (@(posedge clk) disable iff (rst)
        bus_reset |-> !$past(own_sel_drive));

    assert_free_clears_R10: assert property (@(posedge clk) disable iff (rst)
        bus_free |=> (!sel_status[4] && !drive_bsy && !sel_latched));
endmodule

bind bus_select_detect bsd_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .sel_s        (sel_s),
    .bsy_s        (bsy_s),
    .rst_s        (rst_s),
    .bus_free     (bus_free),
    .own_sel_drive(own_sel_drive),
    .sel_status   (sel_status),
    .drive_bsy    (drive_bsy),
    .sel_latched  (sel_latched),
    .legacy_mode  (legacy_mode),
    .bus_reset    (bus_reset)
);

// File: tb/bus_select_detect_test.sv
module bus_select_detect_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 0, bus_bsy = 0, bus_atn = 0, bus_rst = 0;
    logic [7:0] bus_data = 0, id_enable = 0;
    logic       own_bsy_drive = 0, own_sel_drive = 0, bus_free = 0;
    logic [4:0] sel_status;
    logic       sel_latched, drive_bsy, legacy_mode, bus_reset;

    int checks = 0, fails = 0, pulses = 0, cycles = 0;
    bit done = 0;
    logic exp_legacy = 0;

    bus_select_detect uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_bsy(bus_bsy),
        .bus_atn(bus_atn), .bus_rst(bus_rst), .bus_data(bus_data),
        .id_enable(id_enable), .own_bsy_drive(own_bsy_drive),
        .own_sel_drive(own_sel_drive), .bus_free(bus_free),
        .sel_status(sel_status), .sel_latched(sel_latched),
        .drive_bsy(drive_bsy), .legacy_mode(legacy_mode), .bus_reset(bus_reset)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        cycles++;
        if (bus_reset) pulses++;
        if (cycles > 150000 && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_free();
        bus_free = 1; tick(1); bus_free = 0; tick(1);
    endtask

    function automatic int expect_word(input logic [7:0] d, input logic [7:0] m, input logic a);
        for (int i = 0; i < 8; i++)
            if (d[i] && m[i]) return 16 | (a ? 8 : 0) | i;
        return 0;
    endfunction

    function automatic logic [7:0] mask_of(input int k);
        case (k)
            0: return 8'hFF; 1: return 8'h00; 2: return 8'h01; 3: return 8'h80;
            4: return 8'hA5; 5: return 8'h5A; 6: return 8'h18; default: return 8'hF0;
        endcase
    endfunction

    initial begin
        tick(4);
        // reset state
        check("R5 reset drive", drive_bsy, 0);
        check("R2 reset status", sel_status, 0);
        rst = 0;
        tick(2);
        check("R7 reset latch", sel_latched, 0);
        check("R8 reset pulse", bus_reset, 0);

        // R11 latency: success on third edge after raising selection
        id_enable = 8'hFF; bus_data = 8'h04; bus_atn = 1; tick(1);
        bus_sel = 1;
        repeat (2) @(posedge clk);
        @(negedge clk) check("R11 not yet after two edges", sel_status[4], 0);
        @(posedge clk);
        @(negedge clk) check("R11 set on third edge", sel_status, 16 | 8 | 2);
        check("R5 drive with status", drive_bsy, 1);
        tick(10);
        bus_sel = 0; tick(4);
        check("R7 latch after release", sel_latched, 1);
        // R4: new selection while responding leaves status alone
        bus_data = 8'h01; bus_sel = 1; tick(10);
        check("R4 status kept while driving", sel_status, 16 | 8 | 2);
        bus_sel = 0; tick(3);
        go_free();
        check("R10 free clears", {sel_status, drive_bsy, sel_latched}, 0);

        // R4: own busy drive blocks evaluation
        own_bsy_drive = 1; bus_sel = 1; tick(10);
        check("R4 own busy ignored", sel_status, 0);
        bus_sel = 0; own_bsy_drive = 0; tick(4);

        // R1/R3: busy asserted blocks, busy release evaluates
        bus_data = 8'h40; bus_bsy = 1; bus_sel = 1; tick(8);
        check("R1 busy high no select", sel_status, 0);
        bus_bsy = 0; tick(10);
        check("R3 busy release selects", sel_status, 16 | 8 | 6);
        bus_sel = 0; tick(3); go_free();

        // R10: bus_free on the evaluation edge wins
        bus_data = 8'h08; tick(1);
        bus_sel = 1;
        repeat (2) @(posedge clk);
        @(negedge clk) bus_free = 1;
        @(negedge clk) bus_free = 0;
        tick(10);
        check("R10 free wins same edge", {sel_status, drive_bsy}, 0);
        bus_sel = 0; tick(4);

        // R2/R6 sweep: all data patterns, eight enable masks, ATN alternating
        for (int k = 0; k < 8; k++) begin
            for (int d = 0; d < 256; d++) begin
                logic a;
                int exp;
                a = d[0] ^ d[3] ^ k[0];
                id_enable = mask_of(k); bus_data = 8'(d); bus_atn = a; tick(1);
                bus_sel = 1; tick(12);
                exp = expect_word(8'(d), mask_of(k), a);
                if (exp != 0) exp_legacy = !a;
                check("R2 R6 status word", sel_status, exp);
                check("R6 legacy flag", legacy_mode, exp_legacy);
                check("R5 drive request", drive_bsy, exp != 0);
                bus_sel = 0; tick(3); go_free();
            end
        end

        // R8 glitch and long hold
        pulses = 0;
        bus_rst = 1; tick(10); bus_rst = 0; tick(40);
        check("R8 short glitch", pulses, 0);
        bus_rst = 1; tick(40); bus_rst = 0; tick(10);
        check("R8 long hold", pulses, 1);
        // R9 own selection drive
        pulses = 0; own_sel_drive = 1;
        bus_rst = 1; tick(40); bus_rst = 0; tick(10);
        check("R9 blocked while driving sel", pulses, 0);
        own_sel_drive = 0; tick(4);

        // reset filter and selection together
        pulses = 0; id_enable = 8'hFF; bus_data = 8'h20; bus_atn = 0; tick(1);
        bus_rst = 1; bus_sel = 1; tick(40);
        check("R8 pulse during selection", pulses, 1);
        check("R6 status during reset", sel_status, 16 | 5);
        check("R6 legacy set", legacy_mode, 1);
        bus_rst = 0; bus_sel = 0; tick(4); go_free();

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule